// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the software-visible register file of a twelve-pin general-purpose port. A simple synchronous bus (byte address, write strobe, read strobe, 16-bit write data, 16-bit read data) reaches an output data latch and two write-only aliases. One alias sets latch bits and the other clears them, so single pins can be changed without a read-modify-write. The bus also reaches one configuration register per pin and a register that selects reduced pad drive strength for each pin.

Each pin's configuration register holds a function code and a 2-bit pad code. The function code is exported for a separate peripheral multiplexer. The pad code decodes into output enable, pull-up and pull-down. Reading the data address returns the live, already synchronised pin levels rather than the latch contents. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output latch, every pin configuration register and the drive register are 0. As a result pin_out, pin_oe, pin_pull_up, pin_pull_dn, pin_low_drv and pin_func are all 0.
- R2: A write to byte address 0x00 loads wr_data[11:0] into the output latch. pin_out shows the new value from the cycle after the write edge.
- R3: A read of address 0x00 returns pin_in in bits 11:0 with bits 15:12 zero, independent of the output latch.
- R4: A write to address 0x02 sets each latch bit whose wr_data bit is 1 and leaves the other latch bits unchanged. A read of 0x02 returns 0.
- R5: A write to address 0x04 clears each latch bit whose wr_data bit is 1 and leaves the other latch bits unchanged. A read of 0x04 returns 0.
- R6: Pin n (n = 0..11) has its configuration register at address 0x06 + 2·n. Bits 4:0 are the function code, exported on pin_func[5n+4:5n]. Bits 9:8 are the pad code. Both fields read back in place.
- R7: The pad code decodes as follows: 00 gives an input with no pull, 01 an input with pull-up (pin_pull_up[n]=1), 10 an input with pull-down (pin_pull_dn[n]=1), and 11 an output (pin_oe[n]=1) with no pull.
- R8: The drive register at address 0x1E holds one bit per pin in bits 11:0. A 1 drives pin_low_drv[n] high to select reduced drive, and a 0 selects normal drive. The register reads back.
- R9: Reads of any other address, including odd addresses, return 0. Writes to such addresses change no output and no register.
- R10: rd_data is registered. It carries the read result in the cycle after a cycle with rd_en high, and it is 0 in the cycle after a cycle with rd_en low.
- R11: Register bits outside the defined fields ignore writes and read as 0. These are bits 15:12 of the data and drive registers and bits 15:10 and 7:5 of each configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| pin_in | input | 12 | Synchronised pin levels |
| pin_out | output | 12 | Output latch value per pin |
| pin_oe | output | 12 | Output enable per pin |
| pin_pull_up | output | 12 | Pull-up enable per pin |
| pin_pull_dn | output | 12 | Pull-down enable per pin |
| pin_low_drv | output | 12 | Reduced drive strength per pin |
| pin_func | output | 60 | Function code per pin, 5 bits each, pin 0 lowest |

## Verification
Every register write takes effect on the write edge, so the pad outputs and pin_func carry the new state from the next cycle. The bench drives stimulus on falling edges and compares these outputs against its own model at the falling edge that follows the write. Read results arrive one edge later than the strobe. The driver queues the expected word when it raises rd_en, and the monitor pops and compares that word at the falling edge after a cycle in which its own delayed copy of rd_en was high. An explicit idle check confirms that rd_data returns to 0 once the strobe is gone.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PAD_IN_FLOAT = 2'b00,
      PAD_IN_UP    = 2'b01,
      PAD_IN_DOWN  = 2'b10,
      PAD_OUT      = 2'b11
   } pad_code_e;

   localparam int OFF_DATA      = 'h00;
   localparam int OFF_SET       = 'h02;
   localparam int OFF_CLR       = 'h04;
   localparam int OFF_CFG_BASE  = 'h06;
   localparam int CFG_STRIDE    = 2;
   localparam int PAD_CODE_LSB  = 8;

   function automatic int cfg_offset(input int pin);
      return OFF_CFG_BASE + CFG_STRIDE * pin;
   endfunction

endpackage

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int NUM_PINS = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_en,
   input  logic [NUM_PINS-1:0] load_val,
   input  logic                set_en,
   input  logic [NUM_PINS-1:0] set_mask,
   input  logic                clr_en,
   input  logic [NUM_PINS-1:0] clr_mask,
   output logic [NUM_PINS-1:0] q
);

   logic [NUM_PINS-1:0] set_bits;
   logic [NUM_PINS-1:0] clr_bits;

   assign set_bits = set_en ? set_mask : '0;
   assign clr_bits = clr_en ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load_en)
         q <= load_val;
      else
         q <= (q | set_bits) & ~clr_bits;   // clear dominates set
   end

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
   import gpio_port_pkg::*;
#(
   parameter int FUNC_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [FUNC_W-1:0] wfunc,
   input  logic [1:0]        wcode,
   output logic [FUNC_W-1:0] func,
   output logic [1:0]        code,
   output logic              oe,
   output logic              pu,
   output logic              pd
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         func <= '0;
         code <= PAD_IN_FLOAT;
      end else if (we) begin
         func <= wfunc;
         code <= wcode;
      end
   end

   assign oe = (code == PAD_OUT);
   assign pu = (code == PAD_IN_UP);
   assign pd = (code == PAD_IN_DOWN);

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS = 12,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 8,
   parameter int FUNC_W   = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [NUM_PINS-1:0]        pin_in,
   output logic [NUM_PINS-1:0]        pin_out,
   output logic [NUM_PINS-1:0]        pin_oe,
   output logic [NUM_PINS-1:0]        pin_pull_up,
   output logic [NUM_PINS-1:0]        pin_pull_dn,
   output logic [NUM_PINS-1:0]        pin_low_drv,
   output logic [NUM_PINS*FUNC_W-1:0] pin_func
);

   localparam int OFF_DRIVE = cfg_offset(NUM_PINS);

   // elaboration-time parameter checks
   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must be within 1..DATA_W");
   end
   if (FUNC_W < 1 || FUNC_W > PAD_CODE_LSB) begin : g_bad_func
      $error("FUNC_W must be within 1..PAD_CODE_LSB");
   end
   if (DATA_W < PAD_CODE_LSB + 2) begin : g_bad_data
      $error("DATA_W too narrow for the pad code field");
   end
   if (OFF_DRIVE >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic hit_data, hit_set, hit_clr, hit_drive;
   logic [NUM_PINS-1:0] hit_cfg;

   assign hit_data  = (addr == ADDR_W'(OFF_DATA));
   assign hit_set   = (addr == ADDR_W'(OFF_SET));
   assign hit_clr   = (addr == ADDR_W'(OFF_CLR));
   assign hit_drive = (addr == ADDR_W'(OFF_DRIVE));

   gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (wr_en && hit_data),
      .load_val (wr_data[NUM_PINS-1:0]),
      .set_en   (wr_en && hit_set),
      .set_mask (wr_data[NUM_PINS-1:0]),
      .clr_en   (wr_en && hit_clr),
      .clr_mask (wr_data[NUM_PINS-1:0]),
      .q        (pin_out)
   );

   logic [FUNC_W-1:0] cfg_func [NUM_PINS];
   logic [1:0]        cfg_code [NUM_PINS];

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign hit_cfg[p] = (addr == ADDR_W'(cfg_offset(p)));

      gpio_pin_cfg #(.FUNC_W(FUNC_W)) u_cfg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && hit_cfg[p]),
         .wfunc (wr_data[FUNC_W-1:0]),
         .wcode (wr_data[PAD_CODE_LSB+1:PAD_CODE_LSB]),
         .func  (cfg_func[p]),
         .code  (cfg_code[p]),
         .oe    (pin_oe[p]),
         .pu    (pin_pull_up[p]),
         .pd    (pin_pull_dn[p])
      );

      assign pin_func[p*FUNC_W +: FUNC_W] = cfg_func[p];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_low_drv <= '0;
      else if (wr_en && hit_drive)
         pin_low_drv <= wr_data[NUM_PINS-1:0];
   end

   // read path: one registered stage
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (hit_data)
         rd_next = DATA_W'(pin_in);
      else if (hit_drive)
         rd_next = DATA_W'(pin_low_drv);
      for (int p = 0; p < NUM_PINS; p++) begin
         if (hit_cfg[p]) begin
            rd_next[FUNC_W-1:0]                    = cfg_func[p];
            rd_next[PAD_CODE_LSB+1:PAD_CODE_LSB] = cfg_code[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else
         rd_data <= rd_en ? rd_next : '0;
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
   import gpio_port_pkg::*;
#(
   parameter int NUM_PINS = 12,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 8,
   parameter int FUNC_W   = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   addr,
   input logic                wr_en,
   input logic                rd_en,
   input logic [DATA_W-1:0]   wr_data,
   input logic [DATA_W-1:0]   rd_data,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] pin_pull_up,
   input logic [NUM_PINS-1:0] pin_pull_dn
);

   // R2
   data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_DATA)) |=> pin_out == $past(wr_data[NUM_PINS-1:0]));

   // R4
   set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_SET)) |=>
      (pin_out == ($past(pin_out) | $past(wr_data[NUM_PINS-1:0]))));

   // R5
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_CLR)) |=>
      (pin_out == ($past(pin_out) & ~$past(wr_data[NUM_PINS-1:0]))));

   // R7
   pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_pull_up & pin_pull_dn) == '0) && ((pin_oe & (pin_pull_up | pin_pull_dn)) == '0));

   // R10
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> rd_data == '0);

   // R4
   set_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == ADDR_W'(OFF_SET) || addr == ADDR_W'(OFF_CLR))) |=> rd_data == '0);

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
   .NUM_PINS (NUM_PINS),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .FUNC_W   (FUNC_W)
) u_chk (.*);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;

   localparam int NP = 12;
   localparam int FW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    addr = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [15:0]   wr_data = '0;
   logic [15:0]   rd_data;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe, pin_pull_up, pin_pull_dn, pin_low_drv;
   logic [NP*FW-1:0] pin_func;

   always #5 clk = ~clk;

   gpio_port_regs u_gpio_port_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull_up(pin_pull_up),
      .pin_pull_dn(pin_pull_dn), .pin_low_drv(pin_low_drv), .pin_func(pin_func)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   // reference model
   logic [NP-1:0] m_out = '0;
   logic [NP-1:0] m_drv = '0;
   logic [FW-1:0] m_func [NP];
   logic [1:0]    m_code [NP];

   // scoreboard
   logic [15:0] exp_q [$];
   string       tag_q [$];
   logic        rd_pend = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) rd_pend <= rd_en;

   always @(negedge clk) begin
      if (rd_pend && exp_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, 64'(rd_data), 64'(e));
      end
   end

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic cfg(input int n, input logic [1:0] code, input logic [4:0] fn);
      wr(8'(6 + 2*n), {6'h3F, code, 3'b111, fn});
      m_code[n] = code;
      m_func[n] = fn;
   endtask

   task automatic chk_outs(string tag);
      logic [NP-1:0] e_oe, e_pu, e_pd;
      logic [NP*FW-1:0] e_fn;
      for (int i = 0; i < NP; i++) begin
         e_oe[i] = (m_code[i] == 2'b11);
         e_pu[i] = (m_code[i] == 2'b01);
         e_pd[i] = (m_code[i] == 2'b10);
         e_fn[i*FW +: FW] = m_func[i];
      end
      chk({tag, " pin_out"}, 64'(pin_out), 64'(m_out));
      chk({tag, " oe"}, 64'(pin_oe), 64'(e_oe));
      chk({tag, " pull_up"}, 64'(pin_pull_up), 64'(e_pu));
      chk({tag, " pull_dn"}, 64'(pin_pull_dn), 64'(e_pd));
      chk({tag, " low_drv"}, 64'(pin_low_drv), 64'(m_drv));
      chk({tag, " func"}, 64'(pin_func), 64'(e_fn));
   endtask

   initial begin
      for (int i = 0; i < NP; i++) begin m_func[i] = '0; m_code[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_outs("R1 reset");
      rd(8'h06, 16'h0000, "R1 cfg0 reset");
      rd(8'h1E, 16'h0000, "R1 drive reset");

      // R2 data load, R11 upper bits dropped
      wr(8'h00, 16'hFA5C); m_out = 12'hA5C;
      chk_outs("R2 load");
      // R3 readback is pin level, not latch
      pin_in = 12'h3F0;
      rd(8'h00, 16'h03F0, "R3 pin level");
      pin_in = 12'hFFF;
      rd(8'h00, 16'h0FFF, "R3 pin level all ones");

      // R4 set alias
      wr(8'h02, 16'hF003); m_out = m_out | 12'h003;
      chk_outs("R4 set");
      rd(8'h02, 16'h0000, "R4 set reads 0");
      wr(8'h02, 16'h0000);
      chk_outs("R4 set zero");

      // R5 clear alias
      wr(8'h04, 16'h000C); m_out = m_out & ~12'h00C;
      chk_outs("R5 clear");
      rd(8'h04, 16'h0000, "R5 clear reads 0");
      wr(8'h04, 16'hF800); m_out = m_out & ~12'h800;
      chk_outs("R5 clear msb");

      // R6 / R7 / R11 configuration registers
      cfg(0, 2'b11, 5'h1F);
      cfg(11, 2'b01, 5'h0A);
      cfg(5, 2'b10, 5'h13);
      cfg(3, 2'b00, 5'h01);
      chk_outs("R7 decode");
      rd(8'h06, 16'h031F, "R6 R11 cfg0 readback");
      rd(8'h1C, 16'h010A, "R6 cfg11 readback");
      rd(8'h10, 16'h0213, "R6 cfg5 readback");
      cfg(0, 2'b10, 5'h00);
      chk_outs("R7 recode pin0");

      // R8 drive register
      wr(8'h1E, 16'hFFFF); m_drv = 12'hFFF;
      chk_outs("R8 drive all");
      rd(8'h1E, 16'h0FFF, "R8 R11 drive readback");
      wr(8'h1E, 16'h0421); m_drv = 12'h421;
      chk_outs("R8 drive pattern");

      // R9 unmapped and odd addresses
      wr(8'h20, 16'hFFFF);
      wr(8'h07, 16'hFFFF);
      wr(8'h01, 16'hFFFF);
      wr(8'h3E, 16'h0000);
      chk_outs("R9 unmapped write");
      rd(8'h06, 16'h0200, "R9 cfg0 untouched");
      rd(8'h20, 16'h0000, "R9 unmapped read");
      rd(8'h07, 16'h0000, "R9 odd read");

      // R10 idle read data is zero
      @(negedge clk);
      @(negedge clk);
      chk("R10 idle rd_data", 64'(rd_data), 64'h0);

      repeat (3) @(negedge clk);
      chk("R10 scoreboard drained", 64'(exp_q.size()), 64'h0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule